// File: doc/BRIEF.md
# HELLO Write-Request Packet Framer

The framer turns an upstream write request (a byte count, a target address, routing IDs, a priority and a critical-request flag) and a stream of 64-bit payload words into one outbound packet on a 64-bit request stream. Each packet opens with a single header beat in HELLO layout. The payload beats follow on the same bus, and the final payload beat is marked with `m_last`. Every beat carries `m_keep` and `m_user`.

All three data interfaces use valid/ready handshakes. A beat moves only on a rising clock edge where both valid and ready are high. The output side may lower `m_ready` at any time, including the cycle after the header and the cycle after `m_valid` rises again following a gap. While it does, the pending beat stays frozen on the bus. Upstream payload is pulled only when the output slot is free, so no beat is ever dropped or sent twice.

If the payload source has no word ready, `m_valid` drops in mid-packet. It rises again as soon as the next word is taken in. A new request is taken only when no packet is in flight.

Top module: `hello_req_framer`

## Requirements
- R1: After reset `m_valid` is low, `m_last` is low, `req_ready` is high and `pld_ready` is low.
- R2: The first beat of a packet is the header. Bits [63:56] hold the transaction ID. [55:52] hold the format code, 5 by default. [51:48] hold the sub-type, 4 by default. [46:45] hold `req_prio`, [44] holds `req_crf` and [43:36] hold `req_size`. [33:0] hold `req_addr`. Bits 47, 35 and 34 are zero.
- R3: `req_size` is the payload byte count minus one. The header is followed by exactly `req_size/8 + 1` payload beats (integer division), and these carry the accepted `pld_data` words in order.
- R4: `m_last` is high on the final payload beat and on no other beat. After that beat is accepted, `m_valid` is low on the next cycle.
- R5: `m_keep` is 8'hFF on every beat. `m_user` equals the `req_user` value captured with the request, on every beat of the packet.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_data`, `m_last` and `m_user` hold their values into the next cycle.
- R7: `req_ready` is low from the acceptance of a request until the last beat of its packet has been accepted.
- R8: The transaction ID is 0 for the first packet after reset and increments by one, modulo 256, for each packet.
- R9: When no payload word is offered, `m_valid` may fall in mid-packet. The packet then resumes with the next word and no beat is lost or repeated.
- R10: `pld_ready` is high only while a packet is in flight, payload beats are still owed, and the output slot is empty or being accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer idle, request can be taken |
| req_size | input | 8 | Payload bytes minus one |
| req_addr | input | 34 | Target address |
| req_user | input | 32 | Source/destination IDs for `m_user` |
| req_prio | input | 2 | Packet priority |
| req_crf | input | 1 | Critical-request flag |
| pld_valid | input | 1 | Payload word offered |
| pld_ready | output | 1 | Payload word taken this cycle |
| pld_data | input | 64 | Payload word |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Sink accepts the beat |
| m_data | output | 64 | Header or payload beat |
| m_keep | output | 8 | Byte enables, all ones |
| m_last | output | 1 | Final payload beat |
| m_user | output | 32 | Routing IDs of the packet |

## Verification
The properties assume that the payload source provides the promised word count and does not alter `pld_data` while it waits. They also assume that `m_ready` is arbitrary but is driven away from the clock edge. The stimulus feeds exactly `req_size/8 + 1` words per request. It applies ready patterns that always accept, that withdraw ready for one cycle after the header and after each re-raise of valid, and that withdraw it periodically. It also inserts payload gaps so that `m_valid` drops in mid-packet.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic {FS_IDLE = 1'b0, FS_BODY = 1'b1} frm_state_e;

  // header field positions (the sink decodes them)
  localparam int HP_TID_LO   = 56;
  localparam int HP_FMT_LO   = 52;
  localparam int HP_SUB_LO   = 48;
  localparam int HP_PRIO_LO  = 45;
  localparam int HP_CRF      = 44;
  localparam int HP_SIZE_LO  = 36;
  localparam int HP_ADDR_LO  = 0;
endpackage

// File: rtl/frm_hdr_pack.sv
module frm_hdr_pack
  import frm_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int SIZE_W = 8,
  parameter int TID_W  = 8,
  parameter logic [3:0] FMT_CODE = 4'h5,
  parameter logic [3:0] SUB_CODE = 4'h4
) (
  input  logic [TID_W-1:0]  tid,
  input  logic [1:0]        prio,
  input  logic              crf,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] addr,
  output logic [63:0]       hdr
);
  always_comb begin
    hdr = '0;
    hdr[HP_TID_LO  +: TID_W]  = tid;
    hdr[HP_FMT_LO  +: 4]      = FMT_CODE;
    hdr[HP_SUB_LO  +: 4]      = SUB_CODE;
    hdr[HP_PRIO_LO +: 2]      = prio;
    hdr[HP_CRF]               = crf;
    hdr[HP_SIZE_LO +: SIZE_W] = size;
    hdr[HP_ADDR_LO +: ADDR_W] = addr;
  end
endmodule

// File: rtl/frm_beat_cnt.sv
module frm_beat_cnt #(
  parameter int SIZE_W  = 8,
  parameter int LANE_SH = 3,
  parameter int CNT_W   = SIZE_W - LANE_SH + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] size,
  input  logic              take,
  output logic              owed,
  output logic              final_one
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left_q <= '0;
    else if (load)
      left_q <= CNT_W'(size >> LANE_SH) + CNT_W'(1);
    else if (take)
      left_q <= left_q - CNT_W'(1);
  end

  assign owed      = (left_q != '0);
  assign final_one = (left_q == CNT_W'(1));
endmodule

// File: rtl/frm_out_reg.sv
module frm_out_reg #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  input  logic              accept,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              q_last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
      q_last  <= 1'b0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_data  <= load_data;
      q_last  <= load_last;
    end else if (accept) begin
      q_valid <= 1'b0;
      q_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/hello_req_framer.sv
module hello_req_framer
  import frm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 34,
  parameter int SIZE_W = 8,
  parameter int USER_W = 32,
  parameter int TID_W  = 8,
  parameter logic [3:0] FMT_CODE = 4'h5,
  parameter logic [3:0] SUB_CODE = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [USER_W-1:0] req_user,
  input  logic [1:0]        req_prio,
  input  logic              req_crf,
  input  logic              pld_valid,
  output logic              pld_ready,
  input  logic [DATA_W-1:0] pld_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [DATA_W/8-1:0] m_keep,
  output logic              m_last,
  output logic [USER_W-1:0] m_user
);
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_SH = $clog2(LANES);
  localparam int CNT_W   = SIZE_W - LANE_SH + 1;

  frm_state_e        state_q;
  logic [TID_W-1:0]  tid_q;
  logic [USER_W-1:0] user_q;
  logic [63:0]       hdr_w;
  logic              owed, final_one;
  logic              out_fire, slot_free, req_fire, pld_fire;
  logic              ld_en, ld_last;
  logic [DATA_W-1:0] ld_data;

  assign out_fire  = m_valid & m_ready;
  assign slot_free = ~m_valid | m_ready;
  assign req_ready = (state_q == FS_IDLE);
  assign req_fire  = req_valid & req_ready;
  assign pld_ready = (state_q == FS_BODY) & owed & slot_free;
  assign pld_fire  = pld_valid & pld_ready;

  frm_hdr_pack #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TID_W(TID_W),
    .FMT_CODE(FMT_CODE), .SUB_CODE(SUB_CODE)
  ) u_hdr (
    .tid(tid_q), .prio(req_prio), .crf(req_crf),
    .size(req_size), .addr(req_addr), .hdr(hdr_w)
  );

  frm_beat_cnt #(.SIZE_W(SIZE_W), .LANE_SH(LANE_SH), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(req_fire), .size(req_size),
    .take(pld_fire), .owed(owed), .final_one(final_one)
  );

  always_comb begin
    ld_en   = req_fire | pld_fire;
    ld_data = req_fire ? DATA_W'(hdr_w) : pld_data;
    ld_last = pld_fire & final_one;
  end

  frm_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(ld_en), .load_data(ld_data),
    .load_last(ld_last), .accept(out_fire),
    .q_valid(m_valid), .q_data(m_data), .q_last(m_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      tid_q   <= '0;
      user_q  <= '0;
    end else begin
      if (req_fire) begin
        state_q <= FS_BODY;
        tid_q   <= tid_q + TID_W'(1);
        user_q  <= req_user;
      end else if (out_fire && m_last) begin
        state_q <= FS_IDLE;
      end
    end
  end

  assign m_keep = '1;
  assign m_user = user_q;
endmodule

// File: rtl/hello_req_framer_chk.sv
module hello_req_framer_chk #(
  parameter int DATA_W = 64,
  parameter int USER_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              pld_valid,
  input logic              pld_ready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic [DATA_W/8-1:0] m_keep,
  input logic              m_last,
  input logic [USER_W-1:0] m_user
);
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last) && $stable(m_user)));

  a_r5_keep_full: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (&m_keep));

  a_r7_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !m_valid);

  a_r4_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> !m_valid);

  a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    pld_ready |-> (!m_valid || m_ready));

  a_r10_not_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pld_ready |-> !req_ready);
endmodule

bind hello_req_framer hello_req_framer_chk #(.DATA_W(DATA_W), .USER_W(USER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .pld_valid(pld_valid),
  .pld_ready(pld_ready), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .m_keep(m_keep), .m_last(m_last), .m_user(m_user)
);

// File: tb/test_hello_req_framer.sv
module test_hello_req_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_size = '0;
  logic [33:0] req_addr = '0;
  logic [31:0] req_user = '0;
  logic [1:0]  req_prio = '0;
  logic        req_crf = 1'b0;
  logic        pld_valid = 1'b0;
  logic        pld_ready;
  logic [63:0] pld_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [63:0] m_data;
  logic [7:0]  m_keep;
  logic        m_last;
  logic [31:0] m_user;

  int n_chk = 0;
  int n_bad = 0;
  int exp_tid = 0;

  always #2 clk = ~clk;

  hello_req_framer i_hello_req_framer (.*);

  typedef struct packed {
    logic [7:0]  size;
    logic [33:0] addr;
    logic [31:0] user;
    logic [1:0]  prio;
    logic        crf;
    logic [1:0]  rmode;  // 0 always, 1 stall after header/re-raise, 2 periodic
    logic        gmode;  // 1 = payload gaps
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   34'h0_0000_1000, 32'h0001_0002, 2'd0, 1'b0, 2'd0, 1'b0},
    '{8'd7,   34'h3_FFFF_FFF8, 32'hABCD_1234, 2'd1, 1'b1, 2'd1, 1'b0},
    '{8'd8,   34'h1_2345_6780, 32'h0007_0009, 2'd2, 1'b0, 2'd1, 1'b1},
    '{8'd63,  34'h0_0BAD_F000, 32'h1111_2222, 2'd3, 1'b1, 2'd2, 1'b0},
    '{8'd255, 34'h2_0000_0000, 32'hFFFF_0000, 2'd1, 1'b0, 2'd1, 1'b1},
    '{8'd15,  34'h0_0000_0040, 32'h5A5A_A5A5, 2'd0, 1'b1, 2'd2, 1'b1},
    '{8'd100, 34'h1_0000_0001, 32'h0000_FFFF, 2'd2, 1'b1, 2'd0, 1'b1},
    '{8'd31,  34'h0_CAFE_0000, 32'h0123_4567, 2'd3, 1'b0, 2'd1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_pkt(input vec_t v, input int tag);
    int nb = int'(v.size) / 8 + 1;
    int sent = 0, got = 0, cyc = 0, gaps = 0;
    bit taken = 0, done = 0, stall = 0, prev_v = 0, hdr_acc = 0, user_bad = 0, keep_bad = 0, data_bad = 0, last_bad = 0, rdy_bad = 0;
    logic [63:0] pdata = '0;
    logic [63:0] ehdr;
    ehdr = {8'(exp_tid), 4'h5, 4'h4, 1'b0, v.prio, v.crf, v.size, 2'b00, v.addr};
    while (!done && cyc < 3000) begin
      @(negedge clk);
      if (stall)  // R6 held beat
        check(m_valid && m_data == pdata, "R6 hold", m_data, pdata);
      case (v.rmode)
        2'd0: m_ready = 1'b1;
        2'd1: m_ready = !(hdr_acc || (m_valid && !prev_v));
        default: m_ready = (cyc % 3) != 1;
      endcase
      prev_v = m_valid;
      req_valid = !taken;
      req_size = v.size; req_addr = v.addr; req_user = v.user;
      req_prio = v.prio; req_crf = v.crf;
      pld_valid = (sent < nb) && (v.gmode ? (cyc % 4) < 2 : 1'b1);
      pld_data = {8'(tag), 24'h0, 32'(sent)};
      #1;
      if (taken && got > 0 && req_ready) rdy_bad = 1;  // R7
      if (req_valid && req_ready) taken = 1;
      if (pld_valid && pld_ready) sent++;
      if (taken && got > 0 && !m_valid) gaps++;
      hdr_acc = 0;
      if (m_valid && m_ready) begin
        if (got == 0) begin
          check(m_data == ehdr, "R2/R8 header", m_data, ehdr);
          check(!m_last, "R4 no last on header", 64'(m_last), 64'd0);
          hdr_acc = 1;
        end else begin
          if (m_data != {8'(tag), 24'h0, 32'(got - 1)}) data_bad = 1;
          if (m_last != (got == nb)) last_bad = 1;
        end
        if (m_keep != 8'hFF) keep_bad = 1;
        if (m_user != v.user) user_bad = 1;
        got++;
        if (m_last) done = 1;
      end
      stall = m_valid && !m_ready;
      pdata = m_data;
      cyc++;
    end
    req_valid = 1'b0; pld_valid = 1'b0;
    check(got == nb + 1, "R3 beat count", 64'(got), 64'(nb + 1));
    check(!data_bad, "R3/R9 payload order", 64'(data_bad), 64'd0);
    check(!last_bad, "R4 last placement", 64'(last_bad), 64'd0);
    check(!keep_bad && !user_bad, "R5 keep/user", {62'd0, keep_bad, user_bad}, 64'd0);
    check(!rdy_bad, "R7 req_ready low in packet", 64'(rdy_bad), 64'd0);
    if (v.gmode && nb > 2)
      check(gaps > 0, "R9 valid dropped on gap", 64'(gaps), 64'd1);
    @(negedge clk);
    check(!m_valid && req_ready, "R4 idle after last", {62'd0, m_valid, req_ready}, 64'd1);
    exp_tid = (exp_tid + 1) % 256;
  endtask

  initial begin
    #40000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!m_valid && !m_last && req_ready && !pld_ready, "R1 reset",
          {60'd0, m_valid, m_last, req_ready, pld_ready}, 64'h2);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: payload offered while idle is not taken
    pld_valid = 1'b1; m_ready = 1'b1;
    #1;
    check(!pld_ready && !m_valid, "R10 idle ignores payload", {62'd0, pld_ready, m_valid}, 64'd0);
    @(negedge clk);
    check(!m_valid, "R10 nothing emitted", 64'(m_valid), 64'd0);
    pld_valid = 1'b0;

    for (int i = 0; i < NV; i++) run_pkt(VECS[i], i);

    // R8: wrap of the transaction ID over 256 packets
    for (int k = NV; k < 260; k++)
      run_pkt('{8'd0, 34'(k), 32'(k), 2'd0, 1'b0, 2'(k % 3), 1'b0}, k);

    // R6: long output stall with header on the bus
    @(negedge clk);
    m_ready = 1'b0; req_valid = 1'b1; req_size = 8'd9;
    @(negedge clk);
    req_valid = 1'b0; pld_valid = 1'b1; pld_data = 64'h77;
    repeat (5) begin
      @(negedge clk);
      #1;
      check(m_valid && m_data[63:56] == 8'(exp_tid) && !pld_ready, "R6 header frozen",
            m_data, {8'(exp_tid), 56'h0});
    end
    rst_n = 1'b0; pld_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(!m_valid && req_ready, "R1 re-reset", {62'd0, m_valid, req_ready}, 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule